// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block is an eight-stage shift register that takes a whole byte at once and then streams it out one bit at a time. A low level on the load control copies the parallel inputs into every stage. While that control is high, each rising edge of a combined shift clock moves the contents one place toward the last stage. On that edge the serial input fills the first stage. The last stage drives a true output and a complemented output.

The shift clock is built from two external tick lines. Each line is brought into the system clock domain through its own two-flop synchronizer. The synchronized lines are ORed, and a rising edge of the result is turned into a one-cycle shift pulse. Either tick line held high therefore inhibits the other. The load control and the parallel and serial data are sampled directly on the system clock, and load takes priority over any shift.

Top module: `piso_shifter`

## Requirements
- R1: While the active-low reset is asserted, every stage is 0, so `tail_q` reads 0 and `tail_qn` reads 1.
- R2: On each system clock edge with `load_n` low, all stages take `par_data`, whatever the tick lines and `serial_in` do. Bit 0 is the first stage and bit 7 the last, so `tail_q` shows `par_data[7]` after that edge.
- R3: With `load_n` high, a rising edge of (`tick_a` OR `tick_b`) shifts the register once. Stage k takes the old stage k-1, and the first stage takes `serial_in`. Eight shifts present the loaded bits on `tail_q` from bit 7 down to bit 0. The bits shifted in from `serial_in` follow them.
- R4: While either tick line is held high, pulses on the other line cause no shift. Dropping the held line causes no shift either.
- R5: A rising edge of the combined clock whose shift pulse falls in a cycle with `load_n` low is discarded. Raising `load_n` afterwards, with the tick still high, does not shift.
- R6: `tail_qn` is always the complement of `tail_q`.
- R7: A shift becomes visible on the outputs after the third system clock edge that follows the tick input's rise. A tick that stays high for many cycles shifts only once.
- R8: With `load_n` high and no combined-clock rising edge, the stages hold their values for any `serial_in` and `par_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Low: copy parallel data; high: shifting allowed |
| par_data | input | 8 | Parallel data, bit 0 to first stage |
| serial_in | input | 1 | Bit entering the first stage on a shift |
| tick_a | input | 1 | Shift clock line, asynchronous |
| tick_b | input | 1 | Shift clock line, asynchronous, interchangeable with tick_a |
| tail_q | output | 1 | Last stage, true |
| tail_qn | output | 1 | Last stage, complemented |

## Verification
Only the last stage reaches the ports. A corrupted stage k therefore stays hidden until 7-k further shifts carry it to `tail_q`. The bench shifts every loaded byte all the way out so that each stage is seen, and it checks one extra shift to confirm the serial input reached the end. An edge detector that fires twice, or misses an edge, shows as a bit-order slip on the next shift, three system cycles after the tick rises. A load that leaks a stale shift shows within the same window after `load_n` returns high.

// File: rtl/piso_pkg.sv
package piso_pkg;

    // What the stage array does on a given system clock edge.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } piso_op_e;

    // Shortest synchronizer chain that the block accepts.
    localparam int unsigned SYNC_MIN = 2;

endpackage

// File: rtl/piso_sync.sv
module piso_sync
    import piso_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    localparam int unsigned LEN = (DEPTH < SYNC_MIN) ? SYNC_MIN : DEPTH;

    typedef struct packed {
        logic [LEN-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[LEN-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.chain[LEN-1];

endmodule

// File: rtl/piso_edge.sv
module piso_edge #(
    parameter int unsigned LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    output logic             level,
    output logic             shift_pulse
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    // Any line high keeps the combined clock high, which inhibits the others.
    assign level = |lines;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_pulse = level & ~st_q.prev;

    // R7: a combined clock that stays high yields a single pulse.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse |=> !shift_pulse);

    // R4: no pulse while the combined level has been high for two cycles.
    a_r4_held_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (level && $past(level)) |-> !shift_pulse);

endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              shift_pulse,
    input  logic              serial_in,
    input  logic [STAGES-1:0] par_data,
    output logic [STAGES-1:0] stages
);

    typedef struct packed {
        logic [STAGES-1:0] bits;
    } stage_st_t;

    stage_st_t st_d, st_q;
    piso_op_e  op;

    // Load wins over shift; a pulse during load is dropped.
    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (shift_pulse) begin
            op = OP_SHIFT;
        end else begin
            op = OP_HOLD;
        end
    end

    always_comb begin
        st_d = st_q;
        case (op)
            OP_LOAD:  st_d.bits = par_data;
            OP_SHIFT: st_d.bits = {st_q.bits[STAGES-2:0], serial_in};
            default:  st_d.bits = st_q.bits;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stages = st_q.bits;

    // R2: a low load copies the parallel word in one edge.
    a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (stages == $past(par_data)));

    // R3: a pulse with load high moves every bit one place.
    a_r3_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && shift_pulse) |=>
            (stages == {$past(stages[STAGES-2:0]), $past(serial_in)}));

    // R8: without a pulse and without load the stages hold.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !shift_pulse) |=> $stable(stages));

endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
    import piso_pkg::*;
#(
    parameter int unsigned STAGES     = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [STAGES-1:0] par_data,
    input  logic              serial_in,
    input  logic              tick_a,
    input  logic              tick_b,
    output logic              tail_q,
    output logic              tail_qn
);

    localparam int unsigned LINES = 2;
    localparam int unsigned TAIL  = STAGES - 1;

    logic [LINES-1:0]  raw_lines;
    logic [LINES-1:0]  sync_lines;
    logic              comb_level;
    logic              shift_pulse;
    logic [STAGES-1:0] stages;

    assign raw_lines = {tick_b, tick_a};

    for (genvar gi = 0; gi < LINES; gi++) begin : g_sync
        piso_sync #(
            .DEPTH (SYNC_DEPTH)
        ) i_sync (
            .clk      (sys_clk),
            .rst_n    (rst_n),
            .async_in (raw_lines[gi]),
            .sync_out (sync_lines[gi])
        );
    end

    piso_edge #(
        .LINES (LINES)
    ) i_edge (
        .clk         (sys_clk),
        .rst_n       (rst_n),
        .lines       (sync_lines),
        .level       (comb_level),
        .shift_pulse (shift_pulse)
    );

    piso_stages #(
        .STAGES (STAGES)
    ) i_stages (
        .clk         (sys_clk),
        .rst_n       (rst_n),
        .load_n      (load_n),
        .shift_pulse (shift_pulse),
        .serial_in   (serial_in),
        .par_data    (par_data),
        .stages      (stages)
    );

    assign tail_q  = stages[TAIL];
    assign tail_qn = ~stages[TAIL];

    // R4: a pulse needs both synchronized lines low one cycle before.
    a_r4_pulse_from_low: assert property (@(posedge sys_clk) disable iff (!rst_n)
        shift_pulse |-> !$past(|sync_lines));

    // R5: a pulse under load leaves the stages equal to the loaded word.
    a_r5_load_drops_pulse: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (!load_n && shift_pulse) |=> (stages == $past(par_data)));

    // R3: the pulse comes from the synchronized level, not from nowhere.
    a_r3_pulse_has_level: assert property (@(posedge sys_clk) disable iff (!rst_n)
        shift_pulse |-> comb_level);

endmodule

// File: tb/test_piso_shifter.sv
module test_piso_shifter;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;

    logic         sys_clk = 1'b0;
    logic         rst_n   = 1'b0;
    logic         load_n  = 1'b1;
    logic [N-1:0] par_data = '0;
    logic         serial_in = 1'b0;
    logic         tick_a = 1'b0;
    logic         tick_b = 1'b0;
    logic         tail_q;
    logic         tail_qn;

    int n_checks = 0;
    int n_fails  = 0;
    logic [N-1:0] exp_reg = '0;

    always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

    piso_shifter i_piso_shifter (
        .sys_clk   (sys_clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .par_data  (par_data),
        .serial_in (serial_in),
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .tail_q    (tail_q),
        .tail_qn   (tail_qn)
    );

    function automatic logic [N-1:0] next_shift(input logic [N-1:0] cur, input logic sin);
        return {cur[N-2:0], sin};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge sys_clk);
    endtask

    task automatic check(input string req, input logic act, input logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, expv, $time);
        end
    endtask

    task automatic check_tail(input string req);
        check(req, tail_q, exp_reg[N-1]);
        check("R6", tail_qn, ~exp_reg[N-1]);
    endtask

    task automatic do_load(input logic [N-1:0] val);
        load_n   = 1'b0;
        par_data = val;
        cyc(1);
        load_n   = 1'b1;
        exp_reg  = val;
        check_tail("R2");
    endtask

    // Pulse one tick line; the shift lands on the third edge after the rise.
    task automatic pulse(input bit use_b, input bit do_shift);
        if (use_b) tick_b = 1'b1; else tick_a = 1'b1;
        cyc(4);
        if (use_b) tick_b = 1'b0; else tick_a = 1'b0;
        cyc(4);
        if (do_shift) exp_reg = next_shift(exp_reg, serial_in);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge sys_clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        int unsigned seed_sink;
        logic [N-1:0] b;
        seed_sink = $urandom(32'd5177);

        // R1: reset state on the outputs.
        cyc(3);
        check("R1", tail_q, 1'b0);
        check("R1", tail_qn, 1'b1);
        rst_n = 1'b1;
        cyc(2);

        // R3, R6: random bytes shifted out with ones behind them.
        for (int k = 0; k < 10; k++) begin
            b = N'($urandom);
            do_load(b);
            serial_in = 1'b1;
            for (int s = 0; s < N; s++) begin
                pulse(((k + s) % 2) == 1, 1'b1);
                check_tail("R3");
            end
            check("R3", tail_q, 1'b1);
            serial_in = 1'b0;
        end

        // R7: latency of three edges and one shift per rise.
        do_load(8'h40);
        tick_a = 1'b1;
        cyc(2);
        check("R7", tail_q, 1'b0);
        cyc(1);
        check("R7", tail_q, 1'b1);
        cyc(10);
        check("R7", tail_q, 1'b1);
        tick_a = 1'b0;
        cyc(4);
        check("R7", tail_q, 1'b1);

        // R4: b held high inhibits a, then a held high inhibits b.
        do_load(8'hA5);
        serial_in = 1'b0;
        tick_b = 1'b1;
        cyc(4);
        exp_reg = next_shift(exp_reg, serial_in);
        check_tail("R4");
        for (int p = 0; p < 4; p++) begin
            pulse(1'b0, 1'b0);
            check_tail("R4");
        end
        tick_b = 1'b0;
        cyc(4);
        check_tail("R4");
        pulse(1'b0, 1'b1);
        check_tail("R4");
        tick_a = 1'b1;
        cyc(4);
        exp_reg = next_shift(exp_reg, serial_in);
        for (int p = 0; p < 4; p++) begin
            pulse(1'b1, 1'b0);
            check_tail("R4");
        end
        tick_a = 1'b0;
        cyc(4);
        check_tail("R4");

        // R5 and R2: edge during load is dropped; load follows par_data.
        load_n   = 1'b0;
        par_data = 8'h80;
        serial_in = 1'b1;
        tick_a   = 1'b1;
        cyc(5);
        check("R5", tail_q, 1'b1);
        par_data = 8'h7F;
        cyc(1);
        check("R2", tail_q, 1'b0);
        par_data = 8'h80;
        cyc(1);
        check("R2", tail_q, 1'b1);
        load_n  = 1'b1;
        exp_reg = 8'h80;
        cyc(5);
        check_tail("R5");
        tick_a = 1'b0;
        cyc(4);
        check_tail("R5");
        serial_in = 1'b0;
        pulse(1'b1, 1'b1);
        check_tail("R5");

        // R8: hold with no edge while data inputs wander.
        do_load(8'hC3);
        for (int h = 0; h < 20; h++) begin
            serial_in = h[0];
            par_data  = N'($urandom);
            cyc(1);
        end
        check_tail("R8");
        serial_in = 1'b0;
        for (int s = 0; s < N; s++) begin
            pulse(1'b0, 1'b1);
            check_tail("R8");
        end

        finish_run();
    end

endmodule